// File: doc/BRIEF.md
# Predicated Integer Vector Unit

This block is an integer vector functional unit that applies add or subtract to two operand vectors one element at a time, under control of a per-element predicate mask. A command carries an operation, an execution mode and a vector length. The unit sequences element indices on a read-index output. The operand values for that index come back on two input ports in the same cycle. Results leave on a write port whose enable follows the mask, so any element whose predicate is clear keeps its previous destination value.

The same sequencer also maintains the mask register. A compare operation records, for each element below the vector length, whether that element is strictly positive as a signed number. An invert operation flips those same bits. Arithmetic has two modes. In the first mode every element below the length is visited and the write is gated by the mask. In the second mode the unit spends one setup cycle and then visits only the elements whose predicate is set, in ascending order. The mask is visible on an output port so that the surrounding datapath can observe it.

Top module: `pred_vec_unit`

## Requirements
- R1: After synchronous active-low reset, busy and wr_en are 0 and the whole mask reads 0.
- R2: A command is taken only when cmd_valid is high at a clock edge while busy is low. A cmd_valid seen while busy is high is ignored and changes neither the mask, the writes nor the run length.
- R3: Arithmetic codes are 0 (add, opa+opb) and 1 (subtract, opa-opb), both modulo 2^16. In full-scan mode (cmd_dense=0), element i is presented in the i-th cycle after acceptance, for every i below the length. wr_en equals that element's mask bit, and wr_idx equals i.
- R4: In skip mode (cmd_dense=1), arithmetic takes one setup cycle, then one cycle per set mask bit below the length, in ascending index order. Each of those cycles writes, and no other cycle writes.
- R5: Code 2 sets mask bit i, for every i below the length, to 1 exactly when operand A element i is greater than zero as a signed 16-bit value.
- R6: Code 3 complements mask bit i for every i below the length.
- R7: Mask bits at or above the length are left unchanged by codes 2 and 3, and no arithmetic command changes the mask.
- R8: A length of 0 is accepted but does nothing, and busy stays low. A length above VLMAX (8) is treated as VLMAX.
- R9: busy is high from the cycle after acceptance through the cycle of the final element, then low. That is a length of L cycles for full-scan and mask commands, and 1 plus the popcount of the active mask bits for skip mode.
- R10: Mask commands visit every element below the length whatever the value of cmd_dense, and they never raise wr_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 add, 1 subtract, 2 compare-positive to mask, 3 invert mask |
| cmd_dense | input | 1 | 1 selects skip mode for arithmetic |
| cmd_vl | input | 4 | Vector length, clamped to VLMAX |
| busy | output | 1 | Command in progress |
| rd_idx | output | 3 | Element index being read |
| opa | input | 16 | Operand A element at rd_idx |
| opb | input | 16 | Operand B element at rd_idx |
| wr_en | output | 1 | Result write enable |
| wr_idx | output | 3 | Result element index |
| wr_data | output | 16 | Result element value |
| mask_q | output | 8 | Current predicate mask |

## Verification
A new command can arrive in the very cycle in which the unit writes its final element. At that edge the sequencer must both retire the run and refuse the command. The bench provokes this by holding cmd_valid high during a chosen busy cycle, frequently the last one, with an operation that would visibly alter the mask or the destination. The case is judged by comparing the run length, the number of writes, the destination contents and the mask afterwards against a model that treats the extra command as absent.

// File: rtl/pvu_pkg.sv
// Shared types for the predicated vector unit.
package pvu_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_GTZ  = 2'd2,
        OP_MNOT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2
    } st_e;

    function automatic logic is_arith(op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/pvu_alu.sv
// Element datapath: add/subtract result and signed positive test on A.
// Assumes two's complement operands; results wrap modulo 2^EW.
module pvu_alu #(
    parameter int EW = 16
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic          sub,
    output logic [EW-1:0] res,
    output logic          pos
);
    // Arithmetic result and positive flag.
    always_comb begin
        res = sub ? (a - b) : (a + b);
        pos = ~a[EW-1] & (|a);
    end
endmodule

// File: rtl/pvu_mask.sv
// Predicate mask register, written one bit per element by mask commands.
// Assumes VLMAX is a power of two so idx addresses every bit.
module pvu_mask
    import pvu_pkg::*;
#(
    parameter int VLMAX = 8,
    localparam int IW = $clog2(VLMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             elem_act,
    input  op_e              op_q,
    input  logic [IW-1:0]    idx,
    input  logic             pos,
    input  logic [VLMAX-1:0] vl_mask,
    output logic [VLMAX-1:0] mask_q
);
    // Update the addressed mask bit for compare or invert commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (elem_act && op_q == OP_GTZ) begin
            mask_q[idx] <= pos;
        end else if (elem_act && op_q == OP_MNOT) begin
            mask_q[idx] <= ~mask_q[idx];
        end
    end

    p_tail_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mask_q & ~$past(vl_mask)) == ($past(mask_q) & ~$past(vl_mask))));

    p_arith_no_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_act && is_arith(op_q)) |=> $stable(mask_q));
endmodule

// File: rtl/pvu_seq.sv
// Element sequencer: accepts commands while idle, then walks indices either
// densely (all below length) or sparsely (set mask bits only, after a
// one-cycle setup). Assumes VLMAX is a power of two.
module pvu_seq
    import pvu_pkg::*;
#(
    parameter int VLMAX = 8,
    localparam int IW = $clog2(VLMAX),
    localparam int VW = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  op_e              cmd_op,
    input  logic             cmd_dense,
    input  logic [VW-1:0]    cmd_vl,
    input  logic [VLMAX-1:0] mask_q,
    output logic             busy,
    output logic             elem_act,
    output logic [IW-1:0]    idx,
    output op_e              op_q,
    output logic [VLMAX-1:0] vl_mask
);
    st_e             state;
    logic            dense_q;
    logic [VW-1:0]   vl_q;
    logic [VLMAX-1:0] pend_q;
    logic [VLMAX-1:0] pend_nx;
    logic [VW-1:0]   vl_eff;
    logic [VLMAX-1:0] cmd_vmask;
    logic            sparse;

    function automatic logic [VLMAX-1:0] len_mask(logic [VW-1:0] n);
        logic [VLMAX-1:0] m;
        for (int i = 0; i < VLMAX; i++) m[i] = (VW'(i) < n);
        return m;
    endfunction

    function automatic logic [IW-1:0] lowest(logic [VLMAX-1:0] p);
        logic [IW-1:0] r;
        r = '0;
        for (int i = VLMAX - 1; i >= 0; i--) if (p[i]) r = IW'(i);
        return r;
    endfunction

    // Clamp length, derive masks and the pending set after this element.
    always_comb begin
        vl_eff    = (cmd_vl > VW'(VLMAX)) ? VW'(VLMAX) : cmd_vl;
        cmd_vmask = len_mask(vl_eff);
        vl_mask   = len_mask(vl_q);
        pend_nx   = pend_q & ~(VLMAX'(1) << idx);
        sparse    = dense_q && is_arith(op_q);
        busy      = (state != ST_IDLE);
        elem_act  = (state == ST_RUN);
    end

    // Command capture and index stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            pend_q  <= '0;
            op_q    <= OP_ADD;
            dense_q <= 1'b0;
            vl_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    op_q    <= cmd_op;
                    dense_q <= cmd_dense;
                    vl_q    <= vl_eff;
                    idx     <= '0;
                    pend_q  <= mask_q & cmd_vmask;
                    if (vl_eff != '0)
                        state <= (is_arith(cmd_op) && cmd_dense) ? ST_SETUP : ST_RUN;
                end
                ST_SETUP: begin
                    if (pend_q == '0) state <= ST_IDLE;
                    else begin
                        idx   <= lowest(pend_q);
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (sparse) begin
                        pend_q <= pend_nx;
                        if (pend_nx == '0) state <= ST_IDLE;
                        else idx <= lowest(pend_nx);
                    end else if ({1'b0, idx} == vl_q - 1'b1) begin
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_sparse_hits_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_act && sparse) |-> (pend_q[idx] && mask_q[idx]));

    p_idx_in_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        elem_act |-> ({1'b0, idx} < vl_q));
endmodule

// File: rtl/pred_vec_unit.sv
// Top: predicated integer vector unit. Reads operands at rd_idx in the same
// cycle, writes results gated by the mask, and maintains the mask itself.
// Assumes the operand source answers combinationally to rd_idx.
module pred_vec_unit
    import pvu_pkg::*;
#(
    parameter int VLMAX = 8,
    parameter int EW    = 16,
    localparam int IW = $clog2(VLMAX),
    localparam int VW = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_dense,
    input  logic [VW-1:0]    cmd_vl,
    output logic             busy,
    output logic [IW-1:0]    rd_idx,
    input  logic [EW-1:0]    opa,
    input  logic [EW-1:0]    opb,
    output logic             wr_en,
    output logic [IW-1:0]    wr_idx,
    output logic [EW-1:0]    wr_data,
    output logic [VLMAX-1:0] mask_q
);
    logic             elem_act;
    logic [IW-1:0]    idx;
    op_e              op_q;
    logic [VLMAX-1:0] vl_mask;
    logic             pos;

    pvu_seq #(.VLMAX(VLMAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op_e'(cmd_op)),
        .cmd_dense(cmd_dense), .cmd_vl(cmd_vl), .mask_q(mask_q), .busy(busy),
        .elem_act(elem_act), .idx(idx), .op_q(op_q), .vl_mask(vl_mask)
    );

    pvu_alu #(.EW(EW)) u_alu (
        .a(opa), .b(opb), .sub(op_q == OP_SUB), .res(wr_data), .pos(pos)
    );

    pvu_mask #(.VLMAX(VLMAX)) u_mask (
        .clk(clk), .rst_n(rst_n), .elem_act(elem_act), .op_q(op_q), .idx(idx),
        .pos(pos), .vl_mask(vl_mask), .mask_q(mask_q)
    );

    // Port assignments: shared index, mask-gated write enable.
    always_comb begin
        rd_idx = idx;
        wr_idx = idx;
        wr_en  = elem_act && is_arith(op_q) && mask_q[idx];
    end

    p_write_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    p_write_needs_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> mask_q[wr_idx]);

    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !wr_en));
endmodule

// File: tb/pred_vec_unit_tb.sv
`timescale 1ns/1ps
module pred_vec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_dense = 1'b0;
    logic [3:0]  cmd_vl = 4'd0;
    logic        busy;
    logic [2:0]  rd_idx;
    logic [15:0] opa, opb;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [15:0] wr_data;
    logic [7:0]  mask_q;

    logic [15:0] A [8];
    logic [15:0] B [8];
    logic [15:0] Vobs [8];
    logic [15:0] Vexp [8];
    logic [7:0]  Mexp;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    assign opa = A[rd_idx];
    assign opb = B[rd_idx];

    pred_vec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dense(cmd_dense), .cmd_vl(cmd_vl), .busy(busy), .rd_idx(rd_idx),
        .opa(opa), .opb(opb), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mask_q(mask_q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Issue one command; junk_at is the busy cycle in which a stray command is driven.
    task automatic run(input int op, input bit dense, input int vl, input int junk_at);
        int L, pc, exp_cyc, exp_wr, cyc, wrs, last_idx;
        bit order_ok;
        L = (vl > 8) ? 8 : vl;
        pc = 0;
        for (int i = 0; i < L; i++) if (Mexp[i]) pc++;
        if (L == 0) begin exp_cyc = 0; exp_wr = 0; end
        else if (op < 2 && dense) begin exp_cyc = 1 + pc; exp_wr = pc; end
        else begin exp_cyc = L; exp_wr = (op < 2) ? pc : 0; end
        for (int i = 0; i < L; i++) begin
            if (op < 2 && Mexp[i]) Vexp[i] = (op == 1) ? A[i] - B[i] : A[i] + B[i];
            if (op == 2) Mexp[i] = !A[i][15] && (A[i] != 16'h0);
            if (op == 3) Mexp[i] = ~Mexp[i];
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_dense = dense; cmd_vl = 4'(vl);
        @(negedge clk);
        cyc = 0; wrs = 0; last_idx = -1; order_ok = 1'b1;
        cmd_valid = 1'b0;
        while (busy && cyc < 40) begin
            if (wr_en) begin
                Vobs[wr_idx] = wr_data;
                wrs++;
                if (int'(wr_idx) <= last_idx) order_ok = 1'b0;
                if (!dense && op < 2 && int'(wr_idx) != cyc) order_ok = 1'b0;
                last_idx = int'(wr_idx);
            end
            cyc++;
            if (cyc - 1 == junk_at) begin
                cmd_valid = 1'b1; cmd_op = 2'd3; cmd_dense = 1'b0; cmd_vl = 4'd8;
            end else cmd_valid = 1'b0;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(cyc == exp_cyc, (op < 2 && dense) ? "R4/R9 busy length" : "R9/R8 busy length", cyc, exp_cyc);
        chk(wrs == exp_wr, (op < 2) ? "R3/R4 write count" : "R10 no write", wrs, exp_wr);
        chk(order_ok, "R3/R4 index order", int'(order_ok), 1);
        for (int i = 0; i < 8; i++)
            chk(Vobs[i] == Vexp[i], "R3 result element", int'(Vobs[i]), int'(Vexp[i]));
        chk(mask_q == Mexp, (op < 2) ? "R7 arith keeps mask" : "R5/R6/R7 mask", int'(mask_q), int'(Mexp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < 8; i++) begin
            A[i] = '0; B[i] = '0; Vobs[i] = '0; Vexp[i] = '0;
        end
        Mexp = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !wr_en && mask_q == 8'h00, "R1 reset state", {busy, wr_en, mask_q}, 0);
        rst_n = 1'b1;

        // R5 boundaries: zero, most negative, one, most positive, minus one
        A[0] = 16'h0000; A[1] = 16'h8000; A[2] = 16'h0001; A[3] = 16'h7fff;
        A[4] = 16'hffff; A[5] = 16'h0005; A[6] = 16'h0000; A[7] = 16'h1234;
        for (int i = 0; i < 8; i++) B[i] = 16'(i * 16'h1111);
        run(2, 1'b1, 8, -1);          // R5, R10 dense flag ignored
        run(0, 1'b0, 8, 7);           // R3 add, R2 stray in final cycle
        run(1, 1'b1, 6, 2);           // R4 sub skip mode, R2 stray mid-run
        run(3, 1'b0, 5, 4);           // R6/R7 invert low five bits
        run(2, 1'b0, 3, -1);          // R7 bits 3..7 kept
        run(0, 1'b0, 0, -1);          // R8 zero length
        run(1, 1'b0, 12, 7);          // R8 clamp to 8
        for (int i = 0; i < 8; i++) A[i] = 16'hff00;
        run(2, 1'b0, 8, -1);          // all non-positive -> mask 0
        run(0, 1'b1, 8, 0);           // R4 empty mask: setup only

        for (int t = 0; t < 60; t++) begin
            for (int i = 0; i < 8; i++) begin
                A[i] = 16'($urandom);
                B[i] = 16'($urandom);
                if ($urandom_range(0, 3) == 0) A[i] = 16'($urandom_range(0, 2)) - 16'd1;
            end
            run(int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(0, 10)),
                int'($urandom_range(0, 9)));
        end
        summary();
    end
endmodule